// File: doc/BRIEF.md
# Host and Coprocessor Command Mailbox

This block passes 16-bit words in both directions between a host processor and an audio coprocessor that share one clock. The host drops a command into a single-entry command latch and the coprocessor picks it up; the coprocessor answers through a single-entry reply latch that the host reads. Each latch has its own ready flag, so each direction is flow-controlled on its own.

A 2-bit host control register does two jobs. It holds the coprocessor in reset and clears both flags when it reads 00. When it is nonzero it gates two host interrupt reasons. The first, "command slot free", tells the host it may send the next command. The second, "reply waiting", tells the host a reply is ready. A separate command interrupt tells the coprocessor that a command has arrived, and stays up until the coprocessor acknowledges it. Both sides can read the flags through status words whose bit positions are fixed. Firmware on the coprocessor tests those bits directly.

Top module: `cmd_mailbox`

## Requirements
- R1: A host command write (`h_cmd_we_i`) stores `h_cmd_wdata_i`. From the next cycle, `c_cmd_rdata_o` shows that word, the command-ready flag is set and `c_irq_o` is high.
- R2: A coprocessor command read (`c_cmd_re_i`) clears command-ready at the next edge. If a host command write arrives in the same cycle, the write wins and the flag stays set.
- R3: A coprocessor reply write (`c_reply_we_i`) stores `c_reply_wdata_i` on `h_reply_rdata_o` and sets reply-ready. A host reply read (`h_reply_re_i`) clears reply-ready. If both happen in the same cycle, the write wins.
- R4: Reason bit 0 (command slot free) of `h_irq_reason_o` is high exactly when the control register holds 11 and command-ready is clear.
- R5: Reason bit 1 (reply waiting) of `h_irq_reason_o` is high exactly when control bit 1 is set and reply-ready is set.
- R6: `h_irq_o` is the OR of the two reason bits.
- R7: `h_ctrl_rdata_o` carries command-ready on bit 1 and reply-ready on bit 0.
- R8: `c_status_o` carries command-ready on bit 7 and the inverse of reply-ready on bit 6, with all other bits 0. `c_flags_o` carries command-ready on bit 3 and reply-ready on bit 7, with all other bits 0.
- R9: The control register resets to 00. While it holds 00, `c_rst_o` is high. Both flags and `c_irq_o` clear at the same edge the register takes 00, and they stay clear. Latch writes made while the register is 00, including one in the same cycle as the write of 00, are ignored. Any nonzero value releases reset.
- R10: A coprocessor acknowledge (`c_irq_ack_i`) clears `c_irq_o` at the next edge. A host command write in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared by both sides |
| rst_ni | input | 1 | Asynchronous active-low reset |
| h_cmd_we_i | input | 1 | Host writes a command |
| h_cmd_wdata_i | input | 16 | Command word |
| h_reply_re_i | input | 1 | Host reads the reply |
| h_reply_rdata_o | output | 16 | Reply latch contents |
| h_ctrl_we_i | input | 1 | Host writes the control register |
| h_ctrl_wdata_i | input | 2 | Control value |
| h_ctrl_rdata_o | output | 2 | Flag readback: bit 1 command-ready, bit 0 reply-ready |
| h_irq_reason_o | output | 2 | Bit 0 command slot free, bit 1 reply waiting |
| h_irq_o | output | 1 | Host interrupt |
| c_cmd_re_i | input | 1 | Coprocessor reads the command |
| c_cmd_rdata_o | output | 16 | Command latch contents |
| c_reply_we_i | input | 1 | Coprocessor writes a reply |
| c_reply_wdata_i | input | 16 | Reply word |
| c_irq_ack_i | input | 1 | Coprocessor acknowledges the command interrupt |
| c_irq_o | output | 1 | Command interrupt to the coprocessor |
| c_status_o | output | 8 | Coprocessor status word |
| c_flags_o | output | 8 | Coprocessor flag input lines |
| c_rst_o | output | 1 | Coprocessor reset |

## Verification
Every output is derived from registered state. A wrong flag, latch word or control value therefore shows on the ports one cycle after the edge that corrupted it. It shows at once on several outputs: the host readback, both coprocessor status words and the interrupt reasons all repeat the same two flags. The bench keeps a behavioural model and compares all outputs after every edge. A lost command, a missed clear or a reset that fails to flush the flags is reported in the cycle it first becomes visible. Collision cycles (a set and a clear together), writes while reset is held, and the write of 00 itself are driven explicitly before a long random run.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DW    = 16;
  localparam int unsigned CTRL_W    = 2;
  localparam int unsigned STAT_W    = 8;
  // reason vector bit positions
  localparam int unsigned RSN_FREE  = 0;
  localparam int unsigned RSN_REPLY = 1;
  localparam int unsigned RSN_W     = 2;
  // coprocessor status word bit positions
  localparam int unsigned ST_CMD    = 7;
  localparam int unsigned ST_NREP   = 6;
  localparam int unsigned FL_CMD    = 3;
  localparam int unsigned FL_REP    = 7;
  typedef logic [CTRL_W-1:0] ctrl_t;
endpackage

// File: rtl/mbx_latch.sv
module mbx_latch #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic [DW-1:0] data_i,
  input  logic          clr_i,
  input  logic          flush_i,
  output logic [DW-1:0] data_o,
  output logic          rdy_o
);
  logic [DW-1:0] data_q;
  logic          rdy_q;
  logic          take;

  assign take = set_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (take) data_q <= data_i;
      if (flush_i)    rdy_q <= 1'b0;
      else if (set_i) rdy_q <= 1'b1;
      else if (clr_i) rdy_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;

  AST_SET_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flush_i) |=> rdy_o); // R1 R3
  AST_SET_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !flush_i) |=> (data_o == $past(data_i))); // R1 R3
  AST_CLR_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !rdy_o); // R2
  AST_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!rdy_o && $stable(data_o))); // R9
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  ctrl_t            wdata_i,
  input  logic             cmd_rdy_i,
  input  logic             reply_rdy_i,
  output logic             hold_nxt_o,
  output logic             cop_rst_o,
  output logic [RSN_W-1:0] reason_o
);
  ctrl_t ctrl_q, ctrl_d;

  assign ctrl_d = we_i ? wdata_i : ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  // flush acts on the edge where control becomes zero
  assign hold_nxt_o = (ctrl_d == '0);
  assign cop_rst_o  = (ctrl_q == '0);

  assign reason_o[RSN_FREE]  = (ctrl_q == '1) && !cmd_rdy_i;
  assign reason_o[RSN_REPLY] = ctrl_q[1] && reply_rdy_i;

  AST_RST_ON_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i == '0) |=> cop_rst_o); // R9
  AST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i != '0) |=> !cop_rst_o); // R9
  AST_FREE_NEEDS_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reason_o[RSN_FREE] |-> (!cop_rst_o && !cmd_rdy_i)); // R4
  AST_REPLY_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reason_o[RSN_REPLY] |-> reply_rdy_i); // R5
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned DW = MBX_DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_cmd_we_i,
  input  logic [DW-1:0]     h_cmd_wdata_i,
  input  logic              h_reply_re_i,
  output logic [DW-1:0]     h_reply_rdata_o,
  input  logic              h_ctrl_we_i,
  input  logic [CTRL_W-1:0] h_ctrl_wdata_i,
  output logic [1:0]        h_ctrl_rdata_o,
  output logic [RSN_W-1:0]  h_irq_reason_o,
  output logic              h_irq_o,
  input  logic              c_cmd_re_i,
  output logic [DW-1:0]     c_cmd_rdata_o,
  input  logic              c_reply_we_i,
  input  logic [DW-1:0]     c_reply_wdata_i,
  input  logic              c_irq_ack_i,
  output logic              c_irq_o,
  output logic [STAT_W-1:0] c_status_o,
  output logic [STAT_W-1:0] c_flags_o,
  output logic              c_rst_o
);
  logic hold_nxt, cmd_rdy, reply_rdy, cirq_q;

  mbx_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (h_ctrl_we_i),
    .wdata_i     (h_ctrl_wdata_i),
    .cmd_rdy_i   (cmd_rdy),
    .reply_rdy_i (reply_rdy),
    .hold_nxt_o  (hold_nxt),
    .cop_rst_o   (c_rst_o),
    .reason_o    (h_irq_reason_o)
  );

  mbx_latch #(.DW(DW)) u_cmd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (h_cmd_we_i),
    .data_i  (h_cmd_wdata_i),
    .clr_i   (c_cmd_re_i),
    .flush_i (hold_nxt),
    .data_o  (c_cmd_rdata_o),
    .rdy_o   (cmd_rdy)
  );

  mbx_latch #(.DW(DW)) u_reply (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (c_reply_we_i),
    .data_i  (c_reply_wdata_i),
    .clr_i   (h_reply_re_i),
    .flush_i (hold_nxt),
    .data_o  (h_reply_rdata_o),
    .rdy_o   (reply_rdy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cirq_q <= 1'b0;
    else if (hold_nxt)    cirq_q <= 1'b0;
    else if (h_cmd_we_i)  cirq_q <= 1'b1;
    else if (c_irq_ack_i) cirq_q <= 1'b0;
  end

  assign c_irq_o        = cirq_q;
  assign h_irq_o        = |h_irq_reason_o;
  assign h_ctrl_rdata_o = {cmd_rdy, reply_rdy};

  always_comb begin
    c_status_o          = '0;
    c_status_o[ST_CMD]  = cmd_rdy;
    c_status_o[ST_NREP] = !reply_rdy;
    c_flags_o           = '0;
    c_flags_o[FL_CMD]   = cmd_rdy;
    c_flags_o[FL_REP]   = reply_rdy;
  end

  AST_CIRQ_ON_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cmd_we_i && !hold_nxt) |=> c_irq_o); // R1
  AST_CIRQ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_irq_ack_i && !h_cmd_we_i) |=> !c_irq_o); // R10
  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_rst_o |-> (!h_irq_o && !c_irq_o && h_ctrl_rdata_o == 2'b00)); // R9
  AST_STATUS_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_status_o[ST_CMD] == c_flags_o[FL_CMD]) && (c_status_o[ST_NREP] != c_flags_o[FL_REP])); // R8
endmodule

// File: tb/cmd_mailbox_bench.sv
module cmd_mailbox_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        h_cmd_we = 0, h_reply_re = 0, h_ctrl_we = 0;
  logic [15:0] h_cmd_wdata = '0;
  logic [1:0]  h_ctrl_wdata = '0;
  logic        c_cmd_re = 0, c_reply_we = 0, c_irq_ack = 0;
  logic [15:0] c_reply_wdata = '0;
  logic [15:0] h_reply_rdata, c_cmd_rdata;
  logic [1:0]  h_ctrl_rdata, h_irq_reason;
  logic        h_irq, c_irq, c_rst;
  logic [7:0]  c_status, c_flags;

  int checks = 0, fails = 0, cycles = 0;

  // reference state
  int          m_ctrl = 0;
  int          m_cmd = 0, m_rep = 0;
  bit          m_crdy = 0, m_rrdy = 0, m_cirq = 0;

  always #2.5 clk = ~clk;

  cmd_mailbox u_cmd_mailbox (
    .clk_i(clk), .rst_ni(rst_n),
    .h_cmd_we_i(h_cmd_we), .h_cmd_wdata_i(h_cmd_wdata),
    .h_reply_re_i(h_reply_re), .h_reply_rdata_o(h_reply_rdata),
    .h_ctrl_we_i(h_ctrl_we), .h_ctrl_wdata_i(h_ctrl_wdata),
    .h_ctrl_rdata_o(h_ctrl_rdata), .h_irq_reason_o(h_irq_reason), .h_irq_o(h_irq),
    .c_cmd_re_i(c_cmd_re), .c_cmd_rdata_o(c_cmd_rdata),
    .c_reply_we_i(c_reply_we), .c_reply_wdata_i(c_reply_wdata),
    .c_irq_ack_i(c_irq_ack), .c_irq_o(c_irq),
    .c_status_o(c_status), .c_flags_o(c_flags), .c_rst_o(c_rst)
  );

  always @(posedge clk) begin
    int  nctrl;
    bit  hold;
    if (!rst_n) begin
      m_ctrl = 0; m_cmd = 0; m_rep = 0; m_crdy = 0; m_rrdy = 0; m_cirq = 0;
    end else begin
      nctrl = h_ctrl_we ? int'(h_ctrl_wdata) : m_ctrl;
      hold  = (nctrl == 0);
      if (hold) begin
        m_crdy = 0; m_rrdy = 0; m_cirq = 0;
      end else begin
        if (h_cmd_we) begin m_cmd = int'(h_cmd_wdata); m_crdy = 1; m_cirq = 1; end
        else begin
          if (c_cmd_re) m_crdy = 0;
          if (c_irq_ack) m_cirq = 0;
        end
        if (c_reply_we) begin m_rep = int'(c_reply_wdata); m_rrdy = 1; end
        else if (h_reply_re) m_rrdy = 0;
      end
      m_ctrl = nctrl;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    bit fr, rr;
    fr = (m_ctrl == 3) && !m_crdy;
    rr = (m_ctrl >= 2) && m_rrdy;
    chk("R9 reset line", int'(c_rst), int'(m_ctrl == 0));
    chk("R1 command word", int'(c_cmd_rdata), m_cmd);
    chk("R3 reply word", int'(h_reply_rdata), m_rep);
    chk("R7 flag readback", int'(h_ctrl_rdata), {m_crdy, m_rrdy});
    chk("R4 slot free reason", int'(h_irq_reason[0]), int'(fr));
    chk("R5 reply reason", int'(h_irq_reason[1]), int'(rr));
    chk("R6 host irq", int'(h_irq), int'(fr | rr));
    chk("R8 status word", int'(c_status), (int'(m_crdy) << 7) | (int'(!m_rrdy) << 6));
    chk("R8 flag lines", int'(c_flags), (int'(m_crdy) << 3) | (int'(m_rrdy) << 7));
    chk("R10 command irq", int'(c_irq), int'(m_cirq));
  endtask

  // one cycle: compare, then drive
  task automatic step(bit hcw, int hcd, bit hrr, bit hctw, int hctd,
                      bit ccr, bit crw, int crd, bit ack);
    @(negedge clk);
    cycles++;
    compare_all();
    h_cmd_we = hcw; h_cmd_wdata = 16'(hcd); h_reply_re = hrr;
    h_ctrl_we = hctw; h_ctrl_wdata = 2'(hctd);
    c_cmd_re = ccr; c_reply_we = crw; c_reply_wdata = 16'(crd); c_irq_ack = ack;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(2);                                  // R9 reset state: held, flags clear
    step(1, 'h1111, 0, 0, 0, 0, 0, 0, 0);     // R9 command ignored while held
    idle(1);
    step(0, 0, 0, 1, 3, 0, 0, 0, 0);          // release
    idle(2);                                  // R4 slot free
    step(1, 'hA5A5, 0, 0, 0, 0, 0, 0, 0);     // R1
    idle(2);
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);          // R2 read clears
    step(0, 0, 0, 0, 0, 0, 1, 'h1234, 0);     // R3 reply
    idle(1);                                  // R5 reply waiting
    step(1, 'h0BEE, 0, 0, 0, 1, 0, 0, 0);     // R2 write wins over read
    step(0, 0, 1, 0, 0, 0, 1, 'h5678, 0);     // R3 write wins over read
    step(0, 0, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);          // R10 ack clears
    step(1, 'hC0DE, 0, 0, 0, 0, 0, 0, 1);     // R10 write wins over ack
    step(0, 0, 0, 1, 2, 0, 1, 'h9999, 0);     // R4 off under ctrl 10, R5 on
    idle(2);
    step(1, 'h7777, 0, 1, 0, 0, 1, 'h4444, 0); // R9 writes same cycle as 00 ignored
    idle(2);
    step(0, 0, 0, 0, 0, 0, 1, 'h2222, 0);     // R9 reply ignored while held
    step(0, 0, 0, 1, 1, 0, 0, 0, 0);          // ctrl 01: released, no reasons
    step(1, 'h3333, 0, 0, 0, 0, 1, 'h6666, 0);
    idle(2);
    step(0, 0, 0, 1, 3, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      step($urandom_range(0, 3) == 0, int'($urandom_range(0, 65535)),
           $urandom_range(0, 2) == 0, r < 3, int'($urandom_range(0, 3)),
           $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
           int'($urandom_range(0, 65535)), $urandom_range(0, 3) == 0);
    end
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule